// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block drives a parallel RGB display. From the system clock it derives a pixel clock through a programmable divider. It counts pixel clocks along each line and lines down each frame. From those counts it produces an active-high horizontal sync, an active-high vertical sync and a data-enable window. Inside the window it takes one pixel per pixel clock from a valid/ready stream and places it on a 24-bit data bus. A narrow mode keeps only the top 6 bits of each colour component.

Every timing quantity is programmed while the block is disabled. These are the line length, the frame height, the horizontal sync width, the horizontal and vertical delays and the active counts. The vertical sync width is given in pixel clocks, so it does not have to be a whole number of lines. Each delay is measured from the assertion of its own sync. All panel-side outputs change together on the falling edge of the generated pixel clock. The timing never stalls: a missing pixel becomes a black pixel and raises a sticky underrun flag.

Top module: `lcd_timing_gen`

## Requirements
- R1: While enabled, `lcd_pclk` has a period of 2×(`clk_div`+1) system clocks. It is low while disabled. The first falling edge comes 2×(`clk_div`+1) system clocks after enable is seen.
- R2: Number pixel clocks within a line from 0 to `line_len`−1. `lcd_hsync` is high for positions below `hs_width`.
- R3: Number pixel clocks from the start of a frame, where a frame is `line_len`×`frame_lines` clocks. `lcd_vsync` is high for the first `vs_width` of them, which may end part-way through a line.
- R4: `lcd_de` is high when the line position lies in [`hs_delay`, `hs_delay`+`h_active`) and the line number lies in [`v_delay`, `v_delay`+`v_active`).
- R5: In wide mode (`mode18`=0), pixels appear on `lcd_data` unchanged and in the order they were accepted. The bit layout is red [23:16], green [15:8], blue [7:0].
- R6: In narrow mode (`mode18`=1), `lcd_data` carries {6'b0, red[7:2], green[7:2], blue[7:2]}.
- R7: Outside the window `lcd_data` is zero and no input pixel is accepted. `pix_ready` is high only on the system cycle that produces an active pixel.
- R8: If no pixel is valid when an active slot is produced, that slot outputs zero with `lcd_de` high. `underrun` then rises and stays high until the block is disabled. The sync timing is unaffected.
- R9: While disabled, every output is low and the counters are cleared. On enabling, the first pixel clock is line 0, position 0, with both syncs high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low clears it |
| mode18 | input | 1 | Selects 6-bit-per-component output |
| clk_div | input | 16 | Pixel clock divider value |
| line_len | input | 16 | Pixel clocks per line |
| frame_lines | input | 16 | Lines per frame |
| hs_width | input | 16 | Horizontal sync width, pixel clocks |
| hs_delay | input | 16 | Pixel clocks from hsync rise to first active pixel |
| h_active | input | 16 | Active pixels per line |
| vs_width | input | 32 | Vertical sync width, pixel clocks |
| v_delay | input | 16 | Lines from vsync rise to first active line |
| v_active | input | 16 | Active lines per frame |
| pix_data | input | 24 | Incoming pixel, red in the top byte |
| pix_valid | input | 1 | Incoming pixel is present |
| pix_ready | output | 1 | Pixel accepted this cycle |
| lcd_pclk | output | 1 | Pixel clock to the panel |
| lcd_hsync | output | 1 | Horizontal sync, active high |
| lcd_vsync | output | 1 | Vertical sync, active high |
| lcd_de | output | 1 | Active-data window |
| lcd_data | output | 24 | Pixel bus |
| underrun | output | 1 | Sticky missing-pixel flag |

## Verification
The first run uses a divider of 1 in wide mode with a steady stream over two whole frames. It shows that the line and frame wraps repeat and that the syncs and window land on the computed positions. The vertical sync width is chosen to end part-way through a line, which tells width counted in pixel clocks apart from width counted in lines. The second run uses a divider of 0 in narrow mode with a gap in the stream longer than a line. That gap separates the black underrun pixel from a stall, and the narrow packing from a plain pass-through. A third run after re-enabling with a divider of 2 confirms the restart at position 0 and a different clock period.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int COMP_W   = 8;
  localparam int NARROW_W = 6;
  localparam int PIX_W    = 3 * COMP_W;
  localparam int PAD_W    = PIX_W - 3 * NARROW_W;

  typedef struct packed {
    logic [COMP_W-1:0] red;
    logic [COMP_W-1:0] green;
    logic [COMP_W-1:0] blue;
  } rgb_t;
endpackage

// File: rtl/lcdt_pclk_div.sv
module lcdt_pclk_div #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DIVW-1:0] div,
  output logic            pclk,
  output logic            fall_tick
);
  logic [DIVW-1:0] cnt_q, cnt_d;
  logic            pclk_q, pclk_d;
  logic            at_end;

  assign at_end = (cnt_q == div);

  always_comb begin
    cnt_d  = cnt_q;
    pclk_d = pclk_q;
    if (!en) begin
      cnt_d  = '0;
      pclk_d = 1'b0;
    end else if (at_end) begin
      cnt_d  = '0;
      pclk_d = ~pclk_q;
    end else begin
      cnt_d  = cnt_q + DIVW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pclk_q <= pclk_d;
    end
  end

  assign pclk      = pclk_q;
  assign fall_tick = en && at_end && pclk_q;
endmodule

// File: rtl/lcdt_raster.sv
module lcdt_raster #(
  parameter int CW    = 16,
  parameter int VSW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CW-1:0]    line_len,
  input  logic [CW-1:0]    frame_lines,
  input  logic [CW-1:0]    hs_width,
  input  logic [CW-1:0]    hs_delay,
  input  logic [CW-1:0]    h_active,
  input  logic [VSW_W-1:0] vs_width,
  input  logic [CW-1:0]    v_delay,
  input  logic [CW-1:0]    v_active,
  output logic             hsync_c,
  output logic             vsync_c,
  output logic             active_c
);
  localparam int EW = CW + 1;

  logic [CW-1:0]    h_q, h_d, v_q, v_d;
  logic [VSW_W-1:0] fclk_q, fclk_d;
  logic             h_last, v_last, h_in, v_in;

  assign h_last = (h_q == line_len - CW'(1));
  assign v_last = (v_q == frame_lines - CW'(1));

  always_comb begin
    h_d    = h_q;
    v_d    = v_q;
    fclk_d = fclk_q;
    if (!en) begin
      h_d    = '0;
      v_d    = '0;
      fclk_d = '0;
    end else if (tick) begin
      if (fclk_q < vs_width) fclk_d = fclk_q + VSW_W'(1);
      if (h_last) begin
        h_d = '0;
        if (v_last) begin
          v_d    = '0;
          fclk_d = '0;
        end else begin
          v_d = v_q + CW'(1);
        end
      end else begin
        h_d = h_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q    <= '0;
      v_q    <= '0;
      fclk_q <= '0;
    end else begin
      h_q    <= h_d;
      v_q    <= v_d;
      fclk_q <= fclk_d;
    end
  end

  assign h_in = (EW'(h_q) >= EW'(hs_delay)) && (EW'(h_q) < EW'(hs_delay) + EW'(h_active));
  assign v_in = (EW'(v_q) >= EW'(v_delay))  && (EW'(v_q) < EW'(v_delay)  + EW'(v_active));

  assign hsync_c  = en && (h_q < hs_width);
  assign vsync_c  = en && (fclk_q < vs_width);
  assign active_c = en && h_in && v_in;
endmodule

// File: rtl/lcdt_fmt.sv
module lcdt_fmt
  import lcdt_pkg::*;
(
  input  rgb_t             px,
  input  logic             narrow,
  output logic [PIX_W-1:0] bus
);
  localparam int CUT = COMP_W - NARROW_W;

  always_comb begin
    if (narrow)
      bus = {{PAD_W{1'b0}}, px.red[COMP_W-1:CUT], px.green[COMP_W-1:CUT], px.blue[COMP_W-1:CUT]};
    else
      bus = px;
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int CW    = 16,
  parameter int VSW_W = 32,
  parameter int DIVW  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mode18,
  input  logic [DIVW-1:0]  clk_div,
  input  logic [CW-1:0]    line_len,
  input  logic [CW-1:0]    frame_lines,
  input  logic [CW-1:0]    hs_width,
  input  logic [CW-1:0]    hs_delay,
  input  logic [CW-1:0]    h_active,
  input  logic [VSW_W-1:0] vs_width,
  input  logic [CW-1:0]    v_delay,
  input  logic [CW-1:0]    v_active,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_valid,
  output logic             pix_ready,
  output logic             lcd_pclk,
  output logic             lcd_hsync,
  output logic             lcd_vsync,
  output logic             lcd_de,
  output logic [PIX_W-1:0] lcd_data,
  output logic             underrun
);
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic             tick, hsync_c, vsync_c, active_c;
  logic [PIX_W-1:0] fmt_bus;

  lcdt_pclk_div #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_i), .en(enable), .div(clk_div),
    .pclk(lcd_pclk), .fall_tick(tick)
  );

  lcdt_raster #(.CW(CW), .VSW_W(VSW_W)) u_raster (
    .clk(clk), .rst_n(rst_i), .en(enable), .tick(tick),
    .line_len(line_len), .frame_lines(frame_lines),
    .hs_width(hs_width), .hs_delay(hs_delay), .h_active(h_active),
    .vs_width(vs_width), .v_delay(v_delay), .v_active(v_active),
    .hsync_c(hsync_c), .vsync_c(vsync_c), .active_c(active_c)
  );

  lcdt_fmt u_fmt (
    .px(rgb_t'(pix_data)), .narrow(mode18), .bus(fmt_bus)
  );

  logic             hs_q, hs_d, vs_q, vs_d, de_q, de_d, ur_q, ur_d;
  logic [PIX_W-1:0] dat_q, dat_d;

  always_comb begin
    hs_d  = hs_q;
    vs_d  = vs_q;
    de_d  = de_q;
    dat_d = dat_q;
    ur_d  = ur_q;
    if (!enable) begin
      hs_d  = 1'b0;
      vs_d  = 1'b0;
      de_d  = 1'b0;
      dat_d = '0;
      ur_d  = 1'b0;
    end else if (tick) begin
      hs_d  = hsync_c;
      vs_d  = vsync_c;
      de_d  = active_c;
      dat_d = (active_c && pix_valid) ? fmt_bus : '0;
      if (active_c && !pix_valid) ur_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      de_q  <= 1'b0;
      dat_q <= '0;
      ur_q  <= 1'b0;
    end else begin
      hs_q  <= hs_d;
      vs_q  <= vs_d;
      de_q  <= de_d;
      dat_q <= dat_d;
      ur_q  <= ur_d;
    end
  end

  assign pix_ready = tick && active_c;
  assign lcd_hsync = hs_q;
  assign lcd_vsync = vs_q;
  assign lcd_de    = de_q;
  assign lcd_data  = dat_q;
  assign underrun  = ur_q;
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        mode18,
  input logic        pix_ready,
  input logic        lcd_pclk,
  input logic        lcd_hsync,
  input logic        lcd_vsync,
  input logic        lcd_de,
  input logic [23:0] lcd_data,
  input logic        underrun
);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!lcd_pclk && !lcd_hsync && !lcd_vsync && !lcd_de && !underrun && !pix_ready));

  assert_blank_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_de |-> (lcd_data == 24'd0));

  assert_take_then_show_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |=> lcd_de);

  assert_change_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$fell(lcd_pclk)) |->
      ($stable(lcd_hsync) && $stable(lcd_vsync) && $stable(lcd_de)));

  assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && underrun) |=> (underrun || !enable));

  assert_narrow_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode18 && lcd_de) |-> (lcd_data[23:18] == 6'd0));
endmodule

bind lcd_timing_gen lcd_timing_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mode18(mode18),
  .pix_ready(pix_ready), .lcd_pclk(lcd_pclk), .lcd_hsync(lcd_hsync),
  .lcd_vsync(lcd_vsync), .lcd_de(lcd_de), .lcd_data(lcd_data),
  .underrun(underrun)
);

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;
  localparam int CLK_PERIOD = 10;

  localparam int L_LEN = 20;
  localparam int F_LIN = 10;
  localparam int HSW   = 3;
  localparam int HDLY  = 5;
  localparam int HACT  = 8;
  localparam int VSW   = 43;
  localparam int VDLY  = 2;
  localparam int VACT  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        mode18 = 1'b0;
  logic [15:0] clk_div = 16'd1;
  logic [23:0] pix_data = 24'd0;
  logic        pix_valid = 1'b0;
  logic        pix_ready, lcd_pclk, lcd_hsync, lcd_vsync, lcd_de, underrun;
  logic [23:0] lcd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode18(mode18), .clk_div(clk_div),
    .line_len(16'(L_LEN)), .frame_lines(16'(F_LIN)), .hs_width(16'(HSW)),
    .hs_delay(16'(HDLY)), .h_active(16'(HACT)), .vs_width(32'(VSW)),
    .v_delay(16'(VDLY)), .v_active(16'(VACT)),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .lcd_pclk(lcd_pclk), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
    .lcd_de(lcd_de), .lcd_data(lcd_data), .underrun(underrun)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] pattern(input int k);
    return 24'(k * 24'h010305 + 24'h0A1B2C);
  endfunction

  function automatic logic [23:0] narrow(input logic [23:0] p);
    return {6'd0, p[23:18], p[15:10], p[7:2]};
  endfunction

  // scoreboard queue, filled by the driver on each accepted pixel
  logic [23:0] sb_q[$];
  bit drv_on = 0;
  bit gap_on = 0;
  int pix_n  = 0;

  initial forever begin
    @(negedge clk);
    pix_valid = drv_on && !gap_on;
    pix_data  = pattern(pix_n);
    #1;
    if (pix_valid && pix_ready) begin
      sb_q.push_back(mode18 ? narrow(pattern(pix_n)) : pattern(pix_n));
      pix_n++;
    end
  end

  // monitor: one slot per falling edge of the pixel clock
  bit mon_on = 0;
  bit prev_pclk = 0;
  bit exp_ur = 0;
  int cyc = 0;
  int last_fall = 1;
  int slot = 0;

  initial forever begin
    @(negedge clk);
    #2;
    if (mon_on) begin
      cyc++;
      if (prev_pclk && !lcd_pclk) begin
        int h, f, v;
        bit ede;
        logic [23:0] edat;
        h = slot % L_LEN;
        f = slot % (L_LEN * F_LIN);
        v = f / L_LEN;
        ede = (h >= HDLY) && (h < HDLY + HACT) && (v >= VDLY) && (v < VDLY + VACT);
        chk("R1 pclk period", 32'(cyc - last_fall), 32'(2 * (clk_div + 1)));
        last_fall = cyc;
        chk("R2 hsync", 32'(lcd_hsync), 32'(h < HSW));
        chk("R3 vsync", 32'(lcd_vsync), 32'(f < VSW));
        chk("R4 data enable", 32'(lcd_de), 32'(ede));
        if (ede && sb_q.size() > 0) edat = sb_q.pop_front();
        else begin
          edat = 24'd0;
          if (ede) exp_ur = 1;
        end
        chk(ede ? (mode18 ? "R6 narrow data" : "R5 pixel data") : "R7 blank data",
            32'(lcd_data), 32'(edat));
        chk("R8 underrun flag", 32'(underrun), 32'(exp_ur));
        slot++;
      end
      prev_pclk = lcd_pclk;
    end
  end

  task automatic start_run(input logic [15:0] dv, input logic m18);
    @(negedge clk);
    clk_div   = dv;
    mode18    = m18;
    sb_q.delete();
    prev_pclk = 0;
    cyc       = 0;
    last_fall = 1;
    slot      = 0;
    exp_ur    = 0;
    mon_on    = 1;
    drv_on    = 1;
    enable    = 1;
  endtask

  task automatic stop_run();
    @(negedge clk);
    mon_on = 0;
    drv_on = 0;
    enable = 0;
    repeat (3) @(negedge clk);
    #2;
    chk("R9 idle pclk", 32'(lcd_pclk), 0);
    chk("R9 idle syncs", 32'({lcd_hsync, lcd_vsync}), 0);
    chk("R9 idle de", 32'(lcd_de), 0);
    chk("R9 idle data", 32'(lcd_data), 0);
    chk("R9 idle flag", 32'(underrun), 0);
    chk("R7 idle ready", 32'(pix_ready), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #2;
    chk("R9 reset pclk", 32'(lcd_pclk), 0);
    chk("R9 reset outputs", 32'({lcd_hsync, lcd_vsync, lcd_de, underrun}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // wide mode, steady stream, two frames
    start_run(16'd1, 1'b0);
    repeat (1650) @(negedge clk);
    chk("R8 no underrun with steady stream", 32'(underrun), 0);
    stop_run();

    // narrow mode, fastest clock, gap longer than a line
    start_run(16'd0, 1'b1);
    repeat (180) @(negedge clk);
    gap_on = 1;
    repeat (50) @(negedge clk);
    gap_on = 0;
    repeat (200) @(negedge clk);
    #2;
    chk("R8 underrun held", 32'(underrun), 1);
    stop_run();

    // restart at origin with another divider
    start_run(16'd2, 1'b0);
    repeat (1260) @(negedge clk);
    stop_run();
    chk("R7 queue drained", 32'(sb_q.size()), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule